// File: doc/BRIEF.md
# ADC Conversion Status and Error Tracker

This block sits between the digital decimation path of a sigma-delta converter and the processor's register interface. Each time the datapath signals the end of a conversion, the block captures the result word into a holding register and raises a completion interrupt flag. Software reads the result and then clears the flag.

Alongside the result, the block keeps sticky error flags:
- one for clipping in the SINC3 filter path;
- one for clipping in the fast filter path;
- one for overrun, meaning a new result arrived while the previous completion flag was still pending;
- one for a calibration that produced an offset or gain value outside its register range.

An aggregate error output is high whenever any of these four flags is set. The result register is overwritten at every conversion end, even when errors are present. On overrun, the unread previous value is lost.

The clip flags apply to one conversion at a time. A conversion-start strobe clears them, and clip strobes set them. Software clears the completion, overrun and calibration flags by writing a flag word in which the matching bit is 0.

Top module: `adc_status_tracker`

## Requirements
- R1: After reset, every flag output, `err_o` and `result_o` are 0.
- R2: A pulse on `sinc_clip_i` sets `sinc_clip_o` in the next cycle. The flag then holds until a conversion start.
- R3: A pulse on `fast_clip_i` sets `fast_clip_o` in the next cycle. The flag then holds until a conversion start.
- R4: A pulse on `conv_start_i` clears both clip flags in the next cycle. A clip strobe in that same cycle wins, so its flag ends up set.
- R5: A clip strobe in the same cycle as `conv_done_i` is credited to the conversion that is ending. Its flag is 1 in the cycle after the done strobe.
- R6: On `conv_done_i`, the next cycle shows `result_o` equal to `conv_data_i` and `done_o` at 1. This happens whether or not any error flag is set.
- R7: A `conv_done_i` while `done_o` is 1 sets `ovr_o` in the next cycle, and the new data replaces the old. This does not apply when the same cycle carries a software clear of the completion flag.
- R8: A write pulse on `flag_wr_i` clears each flag whose bit in `flag_wr_data_i` is 0. Bit 0 is completion, bit 1 is overrun and bit 2 is calibration error. A bit written as 1 has no effect.
- R9: When a software clear and a setting event fall in the same cycle, the setting event wins.
- R10: `cal_done_i` together with `cal_oor_i` sets `cal_err_o` in the next cycle. `cal_done_i` with `cal_oor_i` low has no effect on `cal_err_o`.
- R11: `err_o` is 1 exactly when at least one of `sinc_clip_o`, `fast_clip_o`, `ovr_o` and `cal_err_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Start of a new conversion |
| sinc_clip_i | input | 1 | SINC3 filter register overflow strobe |
| fast_clip_i | input | 1 | Fast filter register overflow strobe |
| conv_done_i | input | 1 | End of conversion strobe |
| conv_data_i | input | RES_W | Conversion result |
| cal_done_i | input | 1 | Calibration finished strobe |
| cal_oor_i | input | 1 | Calibration value beyond register limits |
| flag_wr_i | input | 1 | Software flag write strobe |
| flag_wr_data_i | input | 3 | Written flag word: bit 0 completion, bit 1 overrun, bit 2 calibration |
| result_o | output | RES_W | Latched conversion result |
| done_o | output | 1 | Completion interrupt flag |
| sinc_clip_o | output | 1 | SINC3 clip flag |
| fast_clip_o | output | 1 | Fast filter clip flag |
| ovr_o | output | 1 | Overrun flag |
| cal_err_o | output | 1 | Calibration range error flag |
| err_o | output | 1 | Aggregate error flag |

## Verification
Every flag in this block is a single register that drives a port directly. A wrong internal state therefore shows up one cycle after the stimulus that caused it.

Two kinds of fault are less visible. The first is a missed overrun: an overrun that is not recorded leaves `ovr_o` and `err_o` low while `result_o` still changes. The second is a wrong priority between a clear and a set in the same cycle, which leaves a flag low that should read 1.

The bench drives these same-cycle collisions deliberately and samples on the following cycle.

// File: rtl/adcst_pkg.sv
package adcst_pkg;
   // Bit positions in the software flag word
   localparam int unsigned FW_DONE = 0;
   localparam int unsigned FW_OVR  = 1;
   localparam int unsigned FW_CAL  = 2;
   localparam int unsigned FW_W    = 3;

   // Clip sources, index into the clip vector
   typedef enum logic [0:0] {
      CLIP_SINC = 1'b0,
      CLIP_FAST = 1'b1
   } clip_src_e;

   localparam int unsigned NUM_CLIP = 2;

   typedef struct packed {
      logic done;
      logic ovr;
      logic cal;
   } sw_clr_t;
endpackage

// File: rtl/adcst_clip_flags.sv
module adcst_clip_flags #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_start_i,
   input  logic [N_SRC-1:0] clip_i,
   output logic [N_SRC-1:0] flag_o
);
   if (N_SRC < 1) begin : g_bad_n
      $error("adcst_clip_flags: N_SRC must be at least 1");
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_o[g] <= 1'b0;
         else if (clip_i[g])
            flag_o[g] <= 1'b1;
         else if (conv_start_i)
            flag_o[g] <= 1'b0;
      end

      // R2 R3 R5: a clip strobe always shows as a set flag next cycle
      a_r2_clip_sets: assert property (@(posedge clk) disable iff (!rst_n)
         clip_i[g] |=> flag_o[g]);
      // R4: start without a clip clears the flag
      a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (conv_start_i && !clip_i[g]) |=> !flag_o[g]);
      // R2 R3: sticky when nothing happens
      a_r3_clip_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!conv_start_i && !clip_i[g]) |=> $stable(flag_o[g]));
   end
endmodule

// File: rtl/adcst_result_reg.sv
module adcst_result_reg #(
   parameter int unsigned RES_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] data_i,
   input  logic             clr_done_i,
   input  logic             clr_ovr_i,
   output logic [RES_W-1:0] result_o,
   output logic             done_o,
   output logic             ovr_o
);
   if (RES_W < 1 || RES_W > 64) begin : g_bad_w
      $error("adcst_result_reg: RES_W out of range 1..64");
   end

   logic pending;
   // A flag still standing at the edge, not cleared in the same cycle
   assign pending = done_o && !clr_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         result_o <= '0;
      else if (conv_done_i)
         result_o <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_o <= 1'b0;
      else if (conv_done_i)
         done_o <= 1'b1;
      else if (clr_done_i)
         done_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr_o <= 1'b0;
      else if (conv_done_i && pending)
         ovr_o <= 1'b1;
      else if (clr_ovr_i)
         ovr_o <= 1'b0;
   end

   // R6: every conversion end loads the data and raises the flag
   a_r6_result_load: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done_i |=> (result_o == $past(data_i)) && done_o);
   // R7: a completion on top of a standing flag is an overrun
   a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && done_o && !clr_done_i) |=> ovr_o);
   // R7: result only moves on a completion
   a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done_i |=> $stable(result_o));
endmodule

// File: rtl/adcst_cal_flag.sv
module adcst_cal_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_done_i,
   input  logic cal_oor_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (cal_done_i && cal_oor_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

   // R10: out-of-range calibration raises the flag
   a_r10_cal_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done_i && cal_oor_i) |=> flag_o);
   // R10: an in-range calibration never raises it
   a_r10_cal_inrange: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !(cal_done_i && cal_oor_i)) |=> !flag_o);
endmodule

// File: rtl/adc_status_tracker.sv
module adc_status_tracker
   import adcst_pkg::*;
#(
   parameter int unsigned RES_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_start_i,
   input  logic             sinc_clip_i,
   input  logic             fast_clip_i,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] conv_data_i,
   input  logic             cal_done_i,
   input  logic             cal_oor_i,
   input  logic             flag_wr_i,
   input  logic [2:0]       flag_wr_data_i,
   output logic [RES_W-1:0] result_o,
   output logic             done_o,
   output logic             sinc_clip_o,
   output logic             fast_clip_o,
   output logic             ovr_o,
   output logic             cal_err_o,
   output logic             err_o
);
   sw_clr_t             clr;
   logic [NUM_CLIP-1:0] clip_vec;
   logic [NUM_CLIP-1:0] clip_flags;

   // Software clear: a 0 written in a flag's position clears it
   assign clr.done = flag_wr_i && !flag_wr_data_i[FW_DONE];
   assign clr.ovr  = flag_wr_i && !flag_wr_data_i[FW_OVR];
   assign clr.cal  = flag_wr_i && !flag_wr_data_i[FW_CAL];

   assign clip_vec[CLIP_SINC] = sinc_clip_i;
   assign clip_vec[CLIP_FAST] = fast_clip_i;

   adcst_clip_flags #(.N_SRC(NUM_CLIP)) u_clip (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_start_i (conv_start_i),
      .clip_i       (clip_vec),
      .flag_o       (clip_flags)
   );

   assign sinc_clip_o = clip_flags[CLIP_SINC];
   assign fast_clip_o = clip_flags[CLIP_FAST];

   adcst_result_reg #(.RES_W(RES_W)) u_res (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_done_i (conv_done_i),
      .data_i      (conv_data_i),
      .clr_done_i  (clr.done),
      .clr_ovr_i   (clr.ovr),
      .result_o    (result_o),
      .done_o      (done_o),
      .ovr_o       (ovr_o)
   );

   adcst_cal_flag u_cal (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_done_i (cal_done_i),
      .cal_oor_i  (cal_oor_i),
      .clr_i      (clr.cal),
      .flag_o     (cal_err_o)
   );

   assign err_o = (|clip_flags) || ovr_o || cal_err_o;

   // R9: a software write never defeats a same-cycle completion
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && clr.done) |=> done_o);
   // R8: a clear with no competing completion drops the flag
   a_r8_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr.done && !conv_done_i) |=> !done_o);
   // R11: a rising aggregate error implies some flag is up
   a_r11_err_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (sinc_clip_o || fast_clip_o || ovr_o || cal_err_o));
endmodule

// File: tb/sim_adc_status_tracker.sv
module sim_adc_status_tracker;
   localparam int unsigned W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         conv_start_i = 0, sinc_clip_i = 0, fast_clip_i = 0;
   logic         conv_done_i = 0, cal_done_i = 0, cal_oor_i = 0, flag_wr_i = 0;
   logic [W-1:0] conv_data_i = '0;
   logic [2:0]   flag_wr_data_i = 3'b111;
   logic [W-1:0] result_o;
   logic         done_o, sinc_clip_o, fast_clip_o, ovr_o, cal_err_o, err_o;

   int checks = 0;
   int errors = 0;
   bit timeout = 0;

   always #10 clk = ~clk;

   adc_status_tracker #(.RES_W(W)) u0 (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      conv_start_i = 0; sinc_clip_i = 0; fast_clip_i = 0; conv_done_i = 0;
      cal_done_i = 0; cal_oor_i = 0; flag_wr_i = 0; flag_wr_data_i = 3'b111;
   endtask

   // Inputs set at a negedge are taken at the next posedge, seen at the next negedge
   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic sw_write(logic [2:0] v);
      flag_wr_i = 1; flag_wr_data_i = v; step();
   endtask

   task automatic t_reset();
      chk("R1 result", result_o, 0);
      chk("R1 flags", {done_o, sinc_clip_o, fast_clip_o, ovr_o, cal_err_o, err_o}, 0);
   endtask

   task automatic t_clean_conv();
      conv_start_i = 1; step();
      conv_data_i = 24'h123456; conv_done_i = 1; step();
      chk("R6 result", result_o, 32'h123456);
      chk("R6 done", done_o, 1);
      chk("R11 no err", err_o, 0);
      sw_write(3'b110);
      chk("R8 done cleared", done_o, 0);
   endtask

   task automatic t_clips();
      conv_start_i = 1; step();
      sinc_clip_i = 1; step();
      chk("R2 sinc set", sinc_clip_o, 1);
      chk("R11 err", err_o, 1);
      step(); step();
      chk("R2 sinc holds", sinc_clip_o, 1);
      chk("R3 fast idle", fast_clip_o, 0);
      fast_clip_i = 1; step();
      chk("R3 fast set", fast_clip_o, 1);
      conv_start_i = 1; step();
      chk("R4 start clears", {sinc_clip_o, fast_clip_o}, 0);
      chk("R11 err drops", err_o, 0);
      conv_start_i = 1; fast_clip_i = 1; step();
      chk("R4 clip wins over start", {sinc_clip_o, fast_clip_o}, 2'b01);
      conv_start_i = 1; step();
   endtask

   task automatic t_clip_at_done();
      sinc_clip_i = 1; conv_done_i = 1; conv_data_i = 24'hABCDEF; step();
      chk("R5 clip credited", sinc_clip_o, 1);
      chk("R6 load despite error", result_o, 32'hABCDEF);
      sw_write(3'b110);
      conv_start_i = 1; step();
   endtask

   task automatic t_overrun();
      conv_done_i = 1; conv_data_i = 24'h000001; step();
      chk("R7 no ovr first", ovr_o, 0);
      conv_done_i = 1; conv_data_i = 24'hFFFFFF; step();
      chk("R7 ovr", ovr_o, 1);
      chk("R7 overwrite", result_o, 32'hFFFFFF);
      chk("R11 err ovr", err_o, 1);
      sw_write(3'b101);
      chk("R8 ovr cleared", ovr_o, 0);
      chk("R8 done untouched", done_o, 1);
      // clear of completion in the same cycle as a new completion
      conv_done_i = 1; conv_data_i = 24'h000002; flag_wr_i = 1; flag_wr_data_i = 3'b110; step();
      chk("R9 done wins", done_o, 1);
      chk("R7 read in time no ovr", ovr_o, 0);
      // set and clear of overrun together
      conv_done_i = 1; flag_wr_i = 1; flag_wr_data_i = 3'b101; step();
      chk("R9 ovr wins", ovr_o, 1);
      sw_write(3'b100);
      chk("R8 both cleared", {done_o, ovr_o}, 0);
   endtask

   task automatic t_cal();
      cal_done_i = 1; cal_oor_i = 0; step();
      chk("R10 in range no flag", cal_err_o, 0);
      cal_done_i = 1; cal_oor_i = 1; step();
      chk("R10 cal err", cal_err_o, 1);
      chk("R11 err cal", err_o, 1);
      sw_write(3'b111);
      chk("R8 write 1 no effect", cal_err_o, 1);
      cal_done_i = 1; cal_oor_i = 1; flag_wr_i = 1; flag_wr_data_i = 3'b011; step();
      chk("R9 cal set wins", cal_err_o, 1);
      sw_write(3'b011);
      chk("R8 cal cleared", cal_err_o, 0);
      chk("R11 err clear", err_o, 0);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_clean_conv();
      t_clips();
      t_clip_at_done();
      t_overrun();
      t_cal();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      timeout = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule